// File: doc/BRIEF.md
# GPIO Change-of-State Monitor

This block watches an eight-pin general-purpose port. Each pin goes through a two-flop synchroniser. When the synchronised level differs from its value one cycle earlier, the pin's sticky change flag is set, but only if detection is enabled for that pin. Software sees the port through a small register bus with four locations:

- the live pin levels;
- a read/write per-pin detect enable;
- two status bytes, each covering one half of the port. The upper nibble holds that half's change flags and the lower nibble holds its live levels.

A flag stays hidden in the status bytes while its pin is disabled or driven as an output. An aggregate `anyChange` output is high while any visible flag is set, so it can feed an interrupt source. One instance serves each serial channel.

Top module: `gpio_change_monitor`

## Requirements
- R1: After reset the enable register reads 0x00, no change flag is set, and `anyChange` is low.
- R2: Reading address 0 returns the pin levels, with bit n equal to pin n. The value is taken after the two-flop synchroniser, so a pin change shows two clock edges after it is driven.
- R3: Address 1 holds the enable register and can be written and read. Bit n set to 1 enables detection on pin n.
- R4: A rising or falling transition on an enabled pin sets that pin's change flag three clock edges after the pin is driven.
- R5: Address 2 returns the change flags of pins 3..0 in bits 7..4 and the levels of pins 3..0 in bits 3..0.
- R6: Address 3 returns the change flags of pins 7..4 in bits 7..4 and the levels of pins 7..4 in bits 3..0.
- R7: A change flag reads 0, and does not drive `anyChange`, while its pin is disabled or while its `pinIsOut` bit is 1. Transitions on a disabled pin are never recorded.
- R8: A read strobe (`regRdEn`) to address 2 or 3 clears the flags of that half of the port on the clock edge. The flags of the other half are left as they were.
- R9: A transition that is detected on the same clock edge as a clearing read of its half leaves the flag set.
- R10: Writing 0 to a pin's enable bit clears that pin's pending change flag. Enabling the pin again does not bring the flag back.
- R11: `anyChange` is high exactly when at least one visible change flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 8 | Raw pin levels from the pads |
| pinIsOut | input | 8 | Per-pin direction; 1 = pin is driven as an output |
| regAddr | input | 2 | Register address (0 levels, 1 enable, 2 low status, 3 high status) |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe; clears status flags when the address is 2 or 3 |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| anyChange | output | 1 | High while any visible change flag is set |

## Verification
Pin patterns are chosen so that each one can only pass with the right behaviour:

- A falling edge in the low half and a falling edge in the high half show whether flags and levels are packed into the correct nibble of the correct status byte.
- A rising edge first seen while the pin is an output tells masking apart from not recording: the flag must be hidden while the pin is an output and appear once the pin becomes an input again.
- An edge on a disabled pin must never be recorded.
- A pending flag that is disabled and then re-enabled separates clearing on disable from masking on read.
- A transition timed to land on the same edge as a clearing read checks that a new change takes priority over the clear.

// File: rtl/gcm_pkg.sv
package gcm_pkg;

  typedef enum logic [1:0] {
    SEL_LEVEL   = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_STAT_LO = 2'd2,
    SEL_STAT_HI = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    enWr;
    logic    clrLo;
    logic    clrHi;
    regSel_e rdSel;
  } ctrlStrb_t;

endpackage

// File: rtl/gcm_ctrl.sv
module gcm_ctrl
  import gcm_pkg::*;
(
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic       regRdEn,
  output ctrlStrb_t  strb
);

  regSel_e sel;

  always_comb begin
    sel        = regSel_e'(regAddr);
    strb.rdSel = sel;
    strb.enWr  = regWrEn && (sel == SEL_ENABLE);
    strb.clrLo = regRdEn && (sel == SEL_STAT_LO);
    strb.clrHi = regRdEn && (sel == SEL_STAT_HI);
  end

endmodule

// File: rtl/gcm_datapath.sv
module gcm_datapath
  import gcm_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinIsOut,
  input  logic [NUM_PINS-1:0] wrData,
  input  ctrlStrb_t           strb,
  output logic [NUM_PINS-1:0] rdData,
  output logic                anyChange
);

  localparam int GROUP = NUM_PINS / 2;

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] levelNow, levelPrev, edgeHit;
  logic [NUM_PINS-1:0] enReg, enNext, flagQ, clrMask, visFlag;

  // synchroniser chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= pinIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign levelNow = syncQ[SYNC_STAGES-1];
  assign edgeHit  = levelNow ^ levelPrev;
  assign enNext   = strb.enWr ? wrData : enReg;
  assign clrMask  = {{GROUP{strb.clrHi}}, {GROUP{strb.clrLo}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelPrev <= '0;
      enReg     <= '0;
      flagQ     <= '0;
    end else begin
      levelPrev <= levelNow;
      enReg     <= enNext;
      flagQ     <= ((flagQ & ~clrMask) | (edgeHit & enReg)) & enNext;
    end
  end

  assign visFlag   = flagQ & enReg & ~pinIsOut;
  assign anyChange = |visFlag;

  always_comb begin
    unique case (strb.rdSel)
      SEL_LEVEL:   rdData = levelNow;
      SEL_ENABLE:  rdData = enReg;
      SEL_STAT_LO: rdData = {visFlag[GROUP-1:0], levelNow[GROUP-1:0]};
      default:     rdData = {visFlag[NUM_PINS-1:GROUP], levelNow[NUM_PINS-1:GROUP]};
    endcase
  end

endmodule

// File: rtl/gpio_change_monitor.sv
module gpio_change_monitor
  import gcm_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinIsOut,
  input  logic [1:0]          regAddr,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [NUM_PINS-1:0] regWrData,
  output logic [NUM_PINS-1:0] regRdData,
  output logic                anyChange
);

  ctrlStrb_t strb;

  gcm_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strb    (strb)
  );

  gcm_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(2)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .pinIsOut  (pinIsOut),
    .wrData    (regWrData),
    .strb      (strb),
    .rdData    (regRdData),
    .anyChange (anyChange)
  );

endmodule

// File: rtl/gcm_checker.sv
module gcm_checker #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinIn,
  input logic [NUM_PINS-1:0] pinIsOut,
  input logic [1:0]          regAddr,
  input logic                regWrEn,
  input logic                regRdEn,
  input logic [NUM_PINS-1:0] regWrData,
  input logic [NUM_PINS-1:0] regRdData,
  input logic                anyChange
);

  localparam int GROUP = NUM_PINS / 2;

  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          upCnt <= '0;
    else if (upCnt < 3) upCnt <= upCnt + 2'd1;

  // R2
  level_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2 && regAddr == 2'd0) |-> regRdData == $past(pinIn, 2));

  // R7
  lo_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2) |-> (regRdData[NUM_PINS-1:GROUP] & pinIsOut[GROUP-1:0]) == '0);

  // R7
  hi_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3) |-> (regRdData[NUM_PINS-1:GROUP] & pinIsOut[NUM_PINS-1:GROUP]) == '0);

  // R11
  all_out_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&pinIsOut) |-> !anyChange);

  // R10
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && regWrData == '0) |=> !anyChange);

endmodule

bind gpio_change_monitor gcm_checker #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/gpio_change_monitor_tb.sv
module gpio_change_monitor_tb;

  logic       clk = 0;
  logic       rstN = 0;
  logic [7:0] pinIn = '0, pinIsOut = '0, regWrData = '0, regRdData;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 0, regRdEn = 0, anyChange;
  int         nChk = 0, nBad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  gpio_change_monitor u_dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic peek(logic [1:0] a, string req, logic [7:0] exp);
    @(negedge clk); regAddr = a; #1;
    chk(req, regRdData, exp);
  endtask

  task automatic rdClr(logic [1:0] a);
    @(negedge clk); regAddr = a; regRdEn = 1;
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic setPins(logic [7:0] v);
    @(negedge clk); pinIn = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_reset();
    peek(2'd1, "R1 enable", 8'h00);
    peek(2'd2, "R1 low status", 8'h00);
    chk("R1 anyChange", {7'd0, anyChange}, 8'h00);
  endtask

  task automatic t_levels();
    @(negedge clk); pinIn = 8'hA5; regAddr = 2'd0;
    @(posedge clk); @(negedge clk);
    chk("R2 one edge", regRdData, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R2 two edges", regRdData, 8'hA5);
    peek(2'd2, "R5 levels low", 8'h05);
    peek(2'd3, "R6 levels high", 8'h0A);
  endtask

  task automatic t_enable();
    wr(2'd1, 8'hFF);
    peek(2'd1, "R3 readback", 8'hFF);
  endtask

  task automatic t_edges();
    setPins(8'hA4);
    peek(2'd2, "R4 R5 fall pin0", 8'h14);
    chk("R11 set", {7'd0, anyChange}, 8'h01);
    setPins(8'h24);
    peek(2'd3, "R6 fall pin7", 8'h82);
    peek(2'd2, "R8 before clear", 8'h14);
    rdClr(2'd2);
    peek(2'd2, "R8 low cleared", 8'h04);
    peek(2'd3, "R8 high kept", 8'h82);
    rdClr(2'd3);
    peek(2'd3, "R8 high cleared", 8'h02);
    chk("R11 clear", {7'd0, anyChange}, 8'h00);
  endtask

  task automatic t_mask();
    @(negedge clk); pinIsOut = 8'h02;
    setPins(8'h26);
    peek(2'd2, "R7 output masked", 8'h06);
    chk("R7 anyChange", {7'd0, anyChange}, 8'h00);
    @(negedge clk); pinIsOut = 8'h00;
    peek(2'd2, "R7 unmasked", 8'h26);
    rdClr(2'd2);
    wr(2'd1, 8'hFE);
    setPins(8'h27);
    peek(2'd2, "R7 disabled", 8'h07);
    wr(2'd1, 8'hFF);
    peek(2'd2, "R7 never recorded", 8'h07);
  endtask

  task automatic t_disable_clears();
    setPins(8'h37);
    peek(2'd3, "R10 pending", 8'h13);
    wr(2'd1, 8'hEF);
    wr(2'd1, 8'hFF);
    peek(2'd3, "R10 cleared", 8'h03);
    chk("R10 anyChange", {7'd0, anyChange}, 8'h00);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); pinIn = 8'h33;
    @(posedge clk); @(posedge clk);
    @(negedge clk); regAddr = 2'd2; regRdEn = 1;
    @(posedge clk);
    @(negedge clk); regRdEn = 0;
    peek(2'd2, "R9 survives clear", 8'h43);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    t_reset();
    t_levels();
    t_enable();
    t_edges();
    t_mask();
    t_disable_clears();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++; nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

endmodule